// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master. It produces the management clock (MDC) and drives and samples the bidirectional management data line to reach registers inside attached Ethernet PHYs. Software programs a clock divisor, an output hold delay and a mode bit through a small 32-bit register port. Frames are then launched as a side effect of register writes. The line is presented as separate output, output-enable and input pins, so that a tri-state pad or a bench model of a PHY can sit outside.

Two frame families are supported. In short-form (Clause 22) mode, the control register names both the PHY and the register. A write to the data register sends a write frame. A write to the control register with its read bit set sends a read frame. In extended (Clause 45) mode, a write to the address register first sends an address frame carrying a 16-bit register address to a port/device pair. Later writes to the data or control register then send the write or read frame. Software polls two busy flags and a read-error flag.

Register offsets (two address bits): 0 configuration, 1 control, 2 address, 3 data. Every frame is 64 bits, sent MSB first: 32 ones, a 2-bit start code, a 2-bit opcode, a 5-bit port address, a 5-bit register/device address, a 2-bit turnaround (10 when the master drives it) and 16 data bits.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0. `bus_rdata` shows the register selected by `bus_addr` one clock later. The configuration fields are: divisor D at [7:0], hold H at [11:8], extended-mode enable at bit 16, read error at bit 30 (read-only), configuration busy at bit 31 (read-only).
- R2: MDC is low while no frame runs. During a frame it spends D+1 core clocks low, then D+1 core clocks high, with a divisor of 0 acting as 1. Its period is therefore 2(D+1) clocks.
- R3: With bit 16 clear, a data-register write sends a short-form write frame. Its start code is 01 and its opcode is 01. The port address comes from control [12:8] and the register from control [4:0]. The turnaround is 10 and the data is the written [15:0]. `mdio_oe` stays high for all 64 bits and drops when the frame ends.
- R4: Each new output bit appears on `mdio_o` exactly H'+1 core clocks after MDC falls, where H' = min(H, D'-1) and D' is the effective divisor. `mdio_o` never changes while MDC is high and the line is driven.
- R5: The data register's bit 31 (data busy) reads 1 from the clock after a frame-starting write to it until its frame has finished.
- R6: A control write with bit 15 set in short-form mode sends a read frame with start code 01 and opcode 10. The master releases the line for the last 18 bits and samples `mdio_i` one core clock after each MDC rise. The 16 data bits, MSB first, then read back in data [15:0] once data busy clears.
- R7: With bit 16 set, an address-register write sends an address frame: start code 00, opcode 00, port from control [12:8], device from control [4:0], turnaround 10, and the written [15:0]. Configuration busy reads 1 until that frame ends. The two busy flags are never both set.
- R8: With bit 16 set, a data-register write sends an extended write frame with start code 00 and opcode 01, and sets data busy.
- R9: With bit 16 set, a control write with bit 15 set sends an extended read frame with start code 00 and opcode 11. The captured data is returned as in R6.
- R10: The read-error bit is set when `mdio_i` is high in the second turnaround bit of a read. It is cleared when the next read frame is launched.
- R11: While either busy flag is set, every register write is ignored. No extra frame starts, and stored values are unchanged.
- R12: With bit 16 clear, an address-register write only stores its value, which reads back; no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Read data lands one clock after the address is presented, and a busy flag is visible in the first read issued after the launching write. The bench therefore samples register values in the falling-edge half-cycle after that clock. Frame contents are observed only at MDC rising edges and compared against a queue filled at launch time. Frame completion is found by polling the busy flags, not by counting cycles. The hold delay and the MDC period are measured in core clocks from the MDC edges and compared with H'+1 and 2(D'+1). Read data reaches the data register at the end of the frame, so it is checked only after busy drops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W       = 32;
  localparam int FRAME_BITS  = 64;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int TA_FIRST    = 46;
  localparam int DATA_FIRST  = 48;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CFG_HOLD_LSB = 8;
  localparam int CFG_EXT_BIT  = 16;
  localparam int CFG_ERR_BIT  = 30;
  localparam int BUSY_BIT     = 31;
  localparam int CTRL_PA_LSB  = 8;
  localparam int CTRL_RD_BIT  = 15;

  typedef enum logic [1:0] {FR_ADDR = 2'd0, FR_WRITE = 2'd1, FR_READ = 2'd2} frame_kind_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        ext,
    input frame_kind_e kind,
    input logic [4:0]  pa,
    input logic [4:0]  ra,
    input logic [15:0] payload
  );
    logic [1:0] st;
    logic [1:0] op;
    st = ext ? 2'b00 : 2'b01;
    case (kind)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      default:  op = ext ? 2'b11 : 2'b10;
    endcase
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [HOLD_W-1:0] hold,
  output logic              mdc,
  output logic              launch_stb,
  output logic              sample_stb,
  output logic              bit_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] hold_eff;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    if (DIV_W'(hold) >= div_eff) hold_eff = div_eff - DIV_W'(1);
    else                         hold_eff = DIV_W'(hold);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == div_eff) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assign launch_stb = run && !mdc && (cnt == hold_eff);
  assign sample_stb = run &&  mdc && (cnt == '0);
  assign bit_end    = run &&  mdc && (cnt == div_eff);

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_read,
  input  logic                  launch_stb,
  input  logic                  sample_stb,
  input  logic                  bit_end,
  input  logic                  mdc_i,
  input  logic                  mdio_i,
  output logic                  run,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rx_data,
  output logic                  rx_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_FIRST + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic [IDX_W-1:0]      bitidx;
  logic [FRAME_BITS-1:0] sreg;
  logic                  rd_q;
  logic                  released;

  assign released = rd_q && (bitidx >= TA_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      bitidx  <= '0;
      sreg    <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
      rx_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run    <= 1'b1;
          bitidx <= '0;
          sreg   <= frame;
          rd_q   <= is_read;
          rx_err <= 1'b0;
        end
      end else begin
        if (launch_stb) begin
          mdio_o  <= released ? 1'b1 : sreg[FRAME_BITS-1];
          mdio_oe <= !released;
          sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
        end
        if (sample_stb && rd_q) begin
          if (bitidx == TA2_IDX && mdio_i) rx_err <= 1'b1;
          if (bitidx >= DAT_IDX) rx_data <= {rx_data[14:0], mdio_i};
        end
        if (bit_end) begin
          if (bitidx == LAST_IDX) begin
            run     <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            bitidx <= bitidx + IDX_W'(1);
          end
        end
      end
    end
  end

  // R4
  mdio_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mdc_i) && mdio_oe) |-> $stable(mdio_o));
  // R3
  release_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mdio_oe && !run));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  start,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  is_read,
  input  logic                  done,
  input  logic [15:0]           rx_data,
  input  logic                  rx_err,
  output logic [DIV_W-1:0]      div,
  output logic [HOLD_W-1:0]     hold
);
  logic        ext_q;
  logic [4:0]  pa_q;
  logic [4:0]  ra_q;
  logic [15:0] addr_q;
  logic [15:0] data_q;
  logic        busy_cfg;
  logic        busy_data;
  logic        rd_err;
  frame_kind_e kind_q;
  logic        busy_any;
  logic        accept;
  logic [BUS_W-1:0] rd_mux;

  assign busy_any = busy_cfg || busy_data;
  assign accept   = bus_wr && !busy_any;
  assign is_read  = (kind_q == FR_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      div       <= '0;
      hold      <= '0;
      ext_q     <= 1'b0;
      pa_q      <= '0;
      ra_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      busy_cfg  <= 1'b0;
      busy_data <= 1'b0;
      rd_err    <= 1'b0;
      kind_q    <= FR_WRITE;
      start     <= 1'b0;
      frame     <= '0;
    end else begin
      start <= 1'b0;
      if (done) begin
        busy_cfg  <= 1'b0;
        busy_data <= 1'b0;
        if (kind_q == FR_READ) begin
          data_q <= rx_data;
          rd_err <= rx_err;
        end
      end
      if (accept) begin
        case (bus_addr)
          REG_CFG: begin
            div   <= bus_wdata[DIV_W-1:0];
            hold  <= bus_wdata[CFG_HOLD_LSB +: HOLD_W];
            ext_q <= bus_wdata[CFG_EXT_BIT];
          end
          REG_CTRL: begin
            pa_q <= bus_wdata[CTRL_PA_LSB +: 5];
            ra_q <= bus_wdata[4:0];
            if (bus_wdata[CTRL_RD_BIT]) begin
              start     <= 1'b1;
              kind_q    <= FR_READ;
              busy_data <= 1'b1;
              rd_err    <= 1'b0;
              frame     <= build_frame(ext_q, FR_READ, bus_wdata[CTRL_PA_LSB +: 5],
                                       bus_wdata[4:0], 16'hFFFF);
            end
          end
          REG_ADDR: begin
            addr_q <= bus_wdata[15:0];
            if (ext_q) begin
              start    <= 1'b1;
              kind_q   <= FR_ADDR;
              busy_cfg <= 1'b1;
              frame    <= build_frame(1'b1, FR_ADDR, pa_q, ra_q, bus_wdata[15:0]);
            end
          end
          default: begin
            data_q    <= bus_wdata[15:0];
            start     <= 1'b1;
            kind_q    <= FR_WRITE;
            busy_data <= 1'b1;
            frame     <= build_frame(ext_q, FR_WRITE, pa_q, ra_q, bus_wdata[15:0]);
          end
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CFG: begin
        rd_mux[DIV_W-1:0]              = div;
        rd_mux[CFG_HOLD_LSB +: HOLD_W] = hold;
        rd_mux[CFG_EXT_BIT]            = ext_q;
        rd_mux[CFG_ERR_BIT]            = rd_err;
        rd_mux[BUSY_BIT]               = busy_cfg;
      end
      REG_CTRL: begin
        rd_mux[CTRL_PA_LSB +: 5] = pa_q;
        rd_mux[4:0]              = ra_q;
      end
      REG_ADDR: rd_mux[15:0] = addr_q;
      default: begin
        rd_mux[15:0]     = data_q;
        rd_mux[BUSY_BIT] = busy_data;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R11
  ignore_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_any && bus_wr) |=> ($stable(div) && $stable(hold) && $stable(ext_q)
                              && $stable(addr_q) && $stable(pa_q) && $stable(ra_q)));
  // R11
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(busy_any));
  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_cfg && busy_data));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic                  start;
  logic [FRAME_BITS-1:0] frame;
  logic                  is_read;
  logic                  done;
  logic [15:0]           rx_data;
  logic                  rx_err;
  logic [DIV_W-1:0]      div;
  logic [HOLD_W-1:0]     hold;
  logic                  run;
  logic                  launch_stb;
  logic                  sample_stb;
  logic                  bit_end;

  mdio_regs #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start),
    .frame(frame), .is_read(is_read), .done(done), .rx_data(rx_data),
    .rx_err(rx_err), .div(div), .hold(hold)
  );

  mdio_clkgen #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(run), .div(div), .hold(hold), .mdc(mdc),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .bit_end(bit_end)
  );

  mdio_shifter shifter_i (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .is_read(is_read),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .bit_end(bit_end),
    .mdc_i(mdc), .mdio_i(mdio_i), .run(run), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .rx_data(rx_data), .rx_err(rx_err)
  );
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queue
  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  localparam logic [63:0] OE_WR = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] OE_RD = 64'hFFFF_FFFF_FFFC_0000;

  task automatic push_frame(input string tag, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d, input bit rd);
    exp_t e;
    e.bits = {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
    e.oe   = rd ? OE_RD : OE_WR;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // PHY model and monitor
  logic        mdc_q, o_q, oe_q;
  int          bitn, since_rise, since_fall, meas_period, meas_hold, frames_seen;
  logic [63:0] cap, capoe;
  logic        phy_rd;
  logic        phy_bad_ta = 1'b0;
  logic [15:0] phy_val = 16'h0;

  always @(negedge clk) begin
    if (rst) begin
      mdc_q = 1'b0; o_q = 1'b1; oe_q = 1'b0; bitn = 0;
      since_rise = 0; since_fall = 0; meas_period = 0; meas_hold = 0;
      frames_seen = 0; cap = '0; capoe = '0; phy_rd = 1'b0; mdio_i = 1'b1;
    end else begin
      since_rise++;
      if (!mdc && mdc_q) since_fall = 0;
      else               since_fall++;
      if (mdio_oe && oe_q && (mdio_o != o_q)) meas_hold = since_fall;
      if (mdc && !mdc_q) begin
        meas_period = since_rise;
        since_rise  = 0;
        cap   = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
        capoe = {capoe[62:0], mdio_oe};
        bitn++;
        if (bitn == 64) begin
          bitn = 0;
          frames_seen++;
          if (exp_q.size() == 0) begin
            chk("R11 unexpected frame", cap, 64'h0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, cap & e.oe, e.bits & e.oe);
            chk(e.tag, capoe, e.oe);
          end
        end
      end
      if (!mdc && mdc_q) begin
        if (bitn == 46) phy_rd = (cap[13:10] == 4'b0110) || (cap[13:10] == 4'b0011);
        if (bitn == 0) phy_rd = 1'b0;
        if (phy_rd && bitn == 47)                   mdio_i = phy_bad_ta;
        else if (phy_rd && bitn >= 48 && bitn <= 63) mdio_i = phy_val[63 - bitn];
        else                                          mdio_i = 1'b1;
      end
      mdc_q = mdc; o_q = mdio_o; oe_q = mdio_oe;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c, d;
    for (int i = 0; i < 20000; i++) begin
      bus_read(2'd0, c);
      bus_read(2'd3, d);
      if (!c[31] && !d[31]) break;
    end
  endtask

  task automatic run_tests();
    logic [31:0] v;
    int seen0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    bus_read(2'd0, v); chk("R1 cfg reset", v, 0);
    bus_read(2'd3, v); chk("R1 data reset", v, 0);
    chk("R2 mdc idle", mdc, 0);
    chk("R3 oe idle", mdio_oe, 0);

    // short-form write, D=2 H=1
    bus_write(2'd0, 32'h0000_0102);
    bus_read(2'd0, v); chk("R1 cfg readback", v, 32'h0000_0102);
    bus_write(2'd1, 32'h0000_0503);
    push_frame("R3 c22 write frame", 2'b01, 2'b01, 5'd5, 5'd3, 16'hBEEF, 0);
    bus_write(2'd3, 32'h0000_BEEF);
    bus_read(2'd3, v); chk("R5 data busy", v[31], 1);
    wait_idle();
    chk("R2 period D=2", meas_period, 6);
    chk("R4 hold H=1", meas_hold, 2);
    bus_read(2'd3, v); chk("R5 busy cleared", v, 32'h0000_BEEF);

    // short-form read
    phy_val = 16'hA5C3;
    push_frame("R6 c22 read frame", 2'b01, 2'b10, 5'd9, 5'h11, 16'h0, 1);
    bus_write(2'd1, 32'h0000_8911);
    wait_idle();
    bus_read(2'd3, v); chk("R6 read data", v, 32'h0000_A5C3);
    bus_read(2'd0, v); chk("R10 no error", v[30], 0);

    // clamp: D=4 H=15 -> H'=3
    bus_write(2'd0, 32'h0000_0F04);
    push_frame("R3 c22 write 2", 2'b01, 2'b01, 5'd9, 5'h11, 16'h3C96, 0);
    bus_write(2'd3, 32'h0000_3C96);
    wait_idle();
    chk("R2 period D=4", meas_period, 10);
    chk("R4 hold clamp", meas_hold, 4);

    // extended mode, D=1 H=2 -> H'=0
    bus_write(2'd0, 32'h0001_0201);
    bus_write(2'd1, 32'h0000_1A07);
    push_frame("R7 c45 address frame", 2'b00, 2'b00, 5'h1A, 5'd7, 16'h1234, 0);
    bus_write(2'd2, 32'h0000_1234);
    bus_read(2'd0, v); chk("R7 cfg busy", v[31], 1);
    bus_read(2'd3, v); chk("R7 data not busy", v[31], 0);
    wait_idle();
    chk("R2 period D=1", meas_period, 4);
    chk("R4 hold clamp 0", meas_hold, 1);

    push_frame("R8 c45 write frame", 2'b00, 2'b01, 5'h1A, 5'd7, 16'h5AA5, 0);
    bus_write(2'd3, 32'h0000_5AA5);
    bus_read(2'd3, v); chk("R8 data busy", v[31], 1);
    wait_idle();

    phy_val = 16'h0F0F;
    push_frame("R9 c45 read frame", 2'b00, 2'b11, 5'h1A, 5'd7, 16'h0, 1);
    bus_write(2'd1, 32'h0000_9A07);
    wait_idle();
    bus_read(2'd3, v); chk("R9 read data", v, 32'h0000_0F0F);

    // read error and its clearing
    phy_bad_ta = 1'b1;
    push_frame("R10 bad ta frame", 2'b00, 2'b11, 5'h1A, 5'd7, 16'h0, 1);
    bus_write(2'd1, 32'h0000_9A07);
    wait_idle();
    bus_read(2'd0, v); chk("R10 error set", v[30], 1);
    phy_bad_ta = 1'b0;
    phy_val = 16'h8001;
    push_frame("R10 good read frame", 2'b00, 2'b11, 5'h1A, 5'd7, 16'h0, 1);
    bus_write(2'd1, 32'h0000_9A07);
    bus_read(2'd0, v); chk("R10 cleared at launch", v[30], 0);
    wait_idle();
    bus_read(2'd0, v); chk("R10 stays clear", v[30], 0);
    bus_read(2'd3, v); chk("R9 read data 2", v, 32'h0000_8001);

    // writes while busy
    push_frame("R11 single frame", 2'b00, 2'b01, 5'h1A, 5'd7, 16'h1111, 0);
    bus_write(2'd3, 32'h0000_1111);
    bus_write(2'd3, 32'h0000_2222);
    bus_write(2'd0, 32'h0000_0000);
    wait_idle();
    bus_read(2'd3, v); chk("R11 data kept", v, 32'h0000_1111);
    bus_read(2'd0, v); chk("R11 cfg kept", v, 32'h0001_0201);

    // address write in short-form mode
    bus_write(2'd0, 32'h0000_0102);
    seen0 = frames_seen;
    bus_write(2'd2, 32'h0000_CAFE);
    repeat (200) @(negedge clk);
    chk("R12 no frame", frames_seen - seen0, 0);
    chk("R12 mdc idle", mdc, 0);
    bus_read(2'd2, v); chk("R12 addr readback", v, 32'h0000_CAFE);
    chk("R11 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule